// File: doc/BRIEF.md
# Self-Correcting Johnson Phase Generator

The block is a four-stage twisted-ring (Johnson) counter used as a timing-signal source. The first stage takes the inverse of the last stage, and every other stage copies its predecessor. Four flip-flops therefore step through eight states. A bank of eight two-input AND terms turns those states into eight phase strobes that do not overlap: in each step of the cycle exactly one strobe is high.

A plain twisted ring that wakes up in one of its eight unused patterns stays in unused patterns forever. Here the third stage does not simply copy the second stage. Its input is `(first OR third) AND second`. With this change every unused pattern drains into the legal cycle after a few shifts, and the legal cycle itself is unchanged.

The counter advances on each clock while `shift_en` is high. A synchronous preload lets the surrounding logic, or a test, place the ring in any pattern. The legal cycle can then be resumed from a chosen phase, and recovery can be exercised from every corrupt pattern.

Top module: `johnson_timing_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 0000 after that edge. The phase bus then reads 00000001, with only phase 0 high. Reset wins over preload and shift.
- R2: With `shift_en` high, and neither `rst` nor `preload_en` high, each clock edge moves the state (written A B C E, which is `state_q[3:0]`) to the next state of the cycle 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001, 0000. A takes the inverse of E and B takes A.
- R3: With `rst`, `preload_en` and `shift_en` all low, the state keeps its value across the clock edge.
- R4: With `preload_en` high and `rst` low, the next state equals `preload_val`, whatever `shift_en` is. The first stage A is bit 3 of `preload_val`.
- R5: `phase_o` is decoded from the current state alone, with no added cycle of delay. Writing `~` for inversion, the bits are as follows: bit 0 = ~A&~E, bit 1 = A&~B, bit 2 = B&~C, bit 3 = C&~E, bit 4 = A&E, bit 5 = ~A&B, bit 6 = ~B&C, bit 7 = ~C&E.
- R6: In each of the eight legal states exactly one phase bit is high. That bit is the state's position in the R2 cycle, counting from 0 for state 0000.
- R7: From any of the eight unused patterns, with `shift_en` held high, the ring reaches a legal state within five clocks and then stays in the legal cycle. The number of shifts needed is 3 from 0010, 1 from 0100, 1 from 0101, 3 from 0110, 2 from 1001, 5 from 1010, 2 from 1011 and 4 from 1101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Advance the ring by one step on this edge |
| preload_en | input | 1 | Load `preload_val` into the ring on this edge |
| preload_val | input | 4 | Pattern to load, A in bit 3 and E in bit 0 |
| state_q | output | 4 | Raw ring state, A in bit 3 and E in bit 0 |
| phase_o | output | 8 | Phase strobes, one-hot in every legal state |

## Verification
Several properties are checked on every clock edge: the reset value, hold while idle, the loaded value, the inverted feedback into A together with the copy into B, one-hot strobes in legal states, and that a legal state always stays legal. A counter in the checker also bounds the number of consecutive shifts spent outside the legal cycle. The exact recovery path from each unused pattern, its length, and the decode of the overlapping strobes in unused patterns are shown only by the bench. The bench steps a behavioural model that is written differently from the RTL and compares against it on every cycle.

// File: rtl/jtg_pkg.sv
package jtg_pkg;

  // What the ring register does on the coming edge.
  typedef enum logic [1:0] {
    JT_HOLD  = 2'd0,
    JT_SHIFT = 2'd1,
    JT_LOAD  = 2'd2,
    JT_CLEAR = 2'd3
  } jt_op_e;

  // Priority: clear, then load, then shift, then hold.
  function automatic jt_op_e jt_pick_op(input logic clear,
                                        input logic load,
                                        input logic shift);
    if (clear) return JT_CLEAR;
    if (load)  return JT_LOAD;
    if (shift) return JT_SHIFT;
    return JT_HOLD;
  endfunction

endpackage

// File: rtl/jtg_next.sv
// Next pattern of the twisted ring. Index 0 is the first stage.
// One stage (FIX_STAGE) gates its copy with (first | own) so that
// unused patterns drain back into the legal cycle.
module jtg_next #(
  parameter int STAGES    = 4,
  parameter int FIX_STAGE = 2
) (
  input  logic [STAGES-1:0] cur,
  output logic [STAGES-1:0] nxt
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign nxt[i] = ~cur[STAGES-1];
    end else if (i == FIX_STAGE) begin : g_fix
      assign nxt[i] = (cur[0] | cur[i]) & cur[i-1];
    end else begin : g_copy
      assign nxt[i] = cur[i-1];
    end
  end

endmodule

// File: rtl/jtg_decode.sv
// Two-input AND decode of a twisted ring into 2*STAGES strobes.
module jtg_decode #(
  parameter int STAGES = 4,
  localparam int PHASES = 2 * STAGES
) (
  input  logic [STAGES-1:0] cur,
  output logic [PHASES-1:0] phase
);

  for (genvar t = 0; t < PHASES; t++) begin : g_term
    if (t == 0) begin : g_empty
      assign phase[t] = ~cur[0] & ~cur[STAGES-1];
    end else if (t < STAGES) begin : g_fill_edge
      assign phase[t] = cur[t-1] & ~cur[t];
    end else if (t == STAGES) begin : g_full
      assign phase[t] = cur[0] & cur[STAGES-1];
    end else begin : g_drain_edge
      assign phase[t] = ~cur[t-STAGES-1] & cur[t-STAGES];
    end
  end

endmodule

// File: rtl/jtg_stage_reg.sv
// Ring flip-flops with clear / load / shift / hold.
module jtg_stage_reg
  import jtg_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  jt_op_e            op,
  input  logic [STAGES-1:0] shifted,
  input  logic [STAGES-1:0] load_val,
  output logic [STAGES-1:0] q
);

  always_ff @(posedge clk) begin
    case (op)
      JT_CLEAR: q <= '0;
      JT_LOAD:  q <= load_val;
      JT_SHIFT: q <= shifted;
      default:  q <= q;
    endcase
  end

endmodule

// File: rtl/johnson_timing_gen.sv
module johnson_timing_gen
  import jtg_pkg::*;
#(
  parameter int STAGES    = 4,
  parameter int FIX_STAGE = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic                preload_en,
  input  logic [STAGES-1:0]   preload_val,
  output logic [STAGES-1:0]   state_q,
  output logic [2*STAGES-1:0] phase_o
);

  localparam int PHASES = 2 * STAGES;

  // Internal order: index 0 is the first stage (A).
  logic [STAGES-1:0] ring_q;
  logic [STAGES-1:0] ring_next;
  logic [STAGES-1:0] ring_load;
  logic [PHASES-1:0] ring_phase;
  jt_op_e            op_sel;

  // Named events, visible to the checker and waveforms.
  logic advance;
  logic load_hit;

  assign op_sel   = jt_pick_op(rst, preload_en, shift_en);
  assign advance  = (op_sel == JT_SHIFT);
  assign load_hit = (op_sel == JT_LOAD);

  // Port order puts the first stage in the top bit.
  for (genvar i = 0; i < STAGES; i++) begin : g_map
    assign state_q[STAGES-1-i] = ring_q[i];
    assign ring_load[i]        = preload_val[STAGES-1-i];
  end

  jtg_next #(.STAGES(STAGES), .FIX_STAGE(FIX_STAGE)) u_next (
    .cur (ring_q),
    .nxt (ring_next)
  );

  jtg_stage_reg #(.STAGES(STAGES)) u_reg (
    .clk      (clk),
    .op       (op_sel),
    .shifted  (ring_next),
    .load_val (ring_load),
    .q        (ring_q)
  );

  jtg_decode #(.STAGES(STAGES)) u_dec (
    .cur   (ring_q),
    .phase (ring_phase)
  );

  assign phase_o = ring_phase;

endmodule

// File: rtl/johnson_timing_chk.sv
module johnson_timing_chk #(
  parameter int STAGES      = 4,
  parameter int MAX_RECOVER = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                shift_en,
  input logic                preload_en,
  input logic [STAGES-1:0]   preload_val,
  input logic [STAGES-1:0]   state_q,
  input logic [2*STAGES-1:0] phase_o
);

  // A legal twisted-ring pattern has at most one change between adjacent stages.
  function automatic logic legal(input logic [STAGES-1:0] v);
    int flips;
    flips = 0;
    for (int i = 0; i < STAGES - 1; i++) if (v[i] != v[i+1]) flips++;
    return (flips <= 1);
  endfunction

  logic [7:0] bad_run;
  always_ff @(posedge clk) begin
    if (rst || preload_en || legal(state_q)) bad_run <= '0;
    else if (shift_en && bad_run != 8'hFF)  bad_run <= bad_run + 8'd1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (state_q == '0));

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!preload_en && !shift_en) |=> $stable(state_q));

  a_r4_preload_takes: assert property (@(posedge clk) disable iff (rst)
    preload_en |=> (state_q == $past(preload_val)));

  a_r2_inverted_feed: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !preload_en) |=>
      (state_q[STAGES-1] == !$past(state_q[0])) &&
      (state_q[STAGES-2] == $past(state_q[STAGES-1])));

  a_r6_onehot_legal: assert property (@(posedge clk) disable iff (rst)
    legal(state_q) |-> ($countones(phase_o) == 1));

  a_r7_stays_legal: assert property (@(posedge clk) disable iff (rst)
    (legal(state_q) && shift_en && !preload_en) |=> legal(state_q));

  a_r7_recover_bound: assert property (@(posedge clk) disable iff (rst)
    bad_run <= 8'(MAX_RECOVER));

endmodule

bind johnson_timing_gen johnson_timing_chk #(.STAGES(STAGES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .shift_en    (shift_en),
  .preload_en  (preload_en),
  .preload_val (preload_val),
  .state_q     (state_q),
  .phase_o     (phase_o)
);

// File: tb/test_johnson_timing_gen.sv
`timescale 1ns/100ps
module test_johnson_timing_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shift_en = 1'b0;
  logic       preload_en = 1'b0;
  logic [3:0] preload_val = 4'd0;
  logic [3:0] state_q;
  logic [7:0] phase_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [3:0] model;

  always #2.5 clk = ~clk;

  johnson_timing_gen i_johnson_timing_gen (
    .clk(clk), .rst(rst), .shift_en(shift_en), .preload_en(preload_en),
    .preload_val(preload_val), .state_q(state_q), .phase_o(phase_o)
  );

  int cycle_pat[8] = '{0, 8, 12, 14, 15, 7, 3, 1};

  function automatic int position(input logic [3:0] v);
    for (int i = 0; i < 8; i++) if (cycle_pat[i] == int'(v)) return i;
    return -1;
  endfunction

  // Behavioural step: shift right, inverted E enters A, C cleared unless A or C was set.
  function automatic logic [3:0] ref_next(input logic [3:0] v);
    int x, n;
    x = int'(v);
    n = (x >> 1) | (((x & 1) ^ 1) << 3);
    if (((x >> 3) & 1) == 0 && ((x >> 1) & 1) == 0) n = n & ~2;
    return 4'(n);
  endfunction

  function automatic logic [7:0] ref_phase(input logic [3:0] v);
    logic a, b, c, e;
    {a, b, c, e} = v;
    return {~c & e, ~b & c, ~a & b, a & e, c & ~e, b & ~c, a & ~b, ~a & ~e};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input string req);
    logic [3:0] nxt;
    int p;
    if (rst) nxt = 4'd0;
    else if (preload_en) nxt = preload_val;
    else if (shift_en) nxt = ref_next(model);
    else nxt = model;
    @(posedge clk); #1;
    model = nxt;
    chk(req, {4'd0, state_q}, {4'd0, model});
    chk("R5", phase_o, ref_phase(model));
    p = position(model);
    if (p >= 0) chk("R6", phase_o, 8'(1 << p));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int bad_pat[8]  = '{2, 4, 5, 6, 9, 10, 11, 13};
  int bad_cost[8] = '{3, 1, 1, 3, 2, 5, 2, 4};

  initial begin
    model = 4'd0;
    // R1: reset state and phase 0
    step("R1"); step("R1");
    chk("R1", phase_o, 8'b0000_0001);

    // R2: two full turns
    rst = 1'b0; shift_en = 1'b1;
    for (int i = 0; i < 16; i++) step("R2");

    // R3: idle hold
    shift_en = 1'b0;
    for (int i = 0; i < 3; i++) step("R3");

    // R2/R3: alternating advance and hold
    for (int i = 0; i < 10; i++) begin
      shift_en = i[0];
      step("R2");
    end

    // R4: preload a legal pattern with shift low, then with shift high
    preload_en = 1'b1; preload_val = 4'b0111; shift_en = 1'b0;
    step("R4");
    preload_val = 4'b1110; shift_en = 1'b1;
    step("R4");
    preload_en = 1'b0;
    step("R2");

    // R7: recovery from every unused pattern
    for (int k = 0; k < 8; k++) begin
      int n;
      preload_en = 1'b1; preload_val = 4'(bad_pat[k]); shift_en = 1'b1;
      step("R4");
      preload_en = 1'b0;
      n = 0;
      while (position(model) < 0 && n < 10) begin
        step("R7");
        n++;
      end
      chk("R7", 8'(n), 8'(bad_cost[k]));
      for (int i = 0; i < 8; i++) step("R7");
    end

    // R1: reset beats preload
    rst = 1'b1; preload_en = 1'b1; preload_val = 4'b1010;
    step("R1");
    chk("R1", phase_o, 8'b0000_0001);
    rst = 1'b0; preload_en = 1'b0;
    for (int i = 0; i < 5; i++) step("R2");

    // R1: reset in mid-run
    rst = 1'b1;
    step("R1");
    rst = 1'b0;
    step("R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule